// File: doc/BRIEF.md
# Interrupt redirection table controller

This block turns a bank of asynchronous interrupt pins into delivery requests for a message sender. Each pin owns one 64-bit programmable entry. The entry holds the vector to be sent, a 3-bit delivery mode and the destination, which is read either as a 4-bit physical ID or as an 8-bit logical set. The entry also selects the pin's polarity, whether the pin is edge or level triggered, and a mask. Every pin passes through a synchronizer and a pulse-width filter. A detected event sets a per-pin delivery-status lock. That lock stays set until the destination accepts the message.

Pending pins are served by a round-robin arbiter, so pin position never gives priority. The chosen request goes out on a valid/ready channel. While `req_valid` is high and `req_ready` is low, the request and all its fields are held unchanged. The transfer completes on the first clock edge where both are high. Only one request is outstanding at a time. After a transfer, the sender returns a single-cycle response on `resp_valid`, where `resp_accept` = 1 means accepted and 0 means retry. The block takes no new request until that response arrives.

Software reaches the table 32 bits at a time through an indexed register port. Level-triggered pins are throttled by a remote-pending bit. That bit is cleared by an end-of-interrupt strobe carrying the same vector.

Top module: `irq_route_top`

## Requirements
- R1: After reset, every entry reads with bit 16 of its low word set (masked), bits 12 and 14 clear, and `req_valid` low.
- R2: Entry n's low word sits at index 10h+2n and its high word at 11h+2n. The low word layout is: vector in 7:0, delivery mode in 10:8, destination mode in 11 (1 = logical), polarity in 13 (1 = active low), trigger in 15 (1 = level) and mask in 16. The high word holds the destination in 31:24. Low bits 31:17 and high bits 23:0 read 0.
- R3: Bit 12 (delivery status) and bit 14 (remote pending) of the low word are read-only, and writes to them have no effect.
- R4: Indices outside 10h–3Fh read as 0, and writes to them change no entry.
- R5: An active pulse that lasts one clock is ignored, and one that lasts two or more clocks is detected. "Active" is pin high, or pin low when bit 13 is 1.
- R6: A detected event sets that entry's delivery status (low bit 12), and only an accept response for that entry clears it.
- R7: Edges on a pin are ignored while its delivery status is set, so a burst yields exactly one message.
- R8: A masked entry sets no delivery status and raises no request.
- R9: A request carries the entry's vector, delivery mode and destination mode. The destination is the full 8-bit field in logical mode, and {0000, field[3:0]} in physical mode.
- R10: `req_valid` holds with stable fields until `req_ready`. Once transferred, no new request appears until a response arrives.
- R11: A retry response keeps the status set and re-queues the entry. Grants rotate round-robin, starting one past the last grant (from input 0 after reset), and never by pin number.
- R12: A level entry stays pending while its pin is active. An accept sets remote pending (low bit 14), and no further message is sent while that bit is set. An end-of-interrupt strobe with a matching vector clears the bit, and a non-matching vector does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_in | input | NUM_IN | Asynchronous interrupt pins |
| reg_idx | input | 8 | Register index |
| reg_wdata | input | 32 | Write data |
| reg_we | input | 1 | Write strobe |
| reg_rdata | output | 32 | Read data for reg_idx |
| req_valid | output | 1 | Delivery request valid |
| req_ready | input | 1 | Sender can take the request |
| req_vector | output | 8 | Request vector |
| req_dmode | output | 3 | Request delivery mode |
| req_logical | output | 1 | Request destination mode (1 = logical) |
| req_dest | output | 8 | Request destination |
| resp_valid | input | 1 | Response strobe from the sender |
| resp_accept | input | 1 | 1 = accepted, 0 = retry |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_vector | input | 8 | Vector of the end-of-interrupt |

## Verification
The bench sweeps every entry's register halves with all-ones and arithmetic patterns, and sweeps every index outside the map. A wrong field mask would expose reserved or read-only bits, and a loose index decode would corrupt a real entry. It fires each of the 24 pins with its own vector, mode and destination. A wrong physical-mode truncation, or a status bit that clears before the accept, shows up as a field or status mismatch. Targeted cases cover the following:
- A one-clock glitch that a missing filter would deliver.
- A second edge during a pending delivery that a missing lock would turn into a second message.
- A masked pin that must stay silent.
- A retry on two pending pins, where a fixed-priority arbiter would re-grant the lower pin.
- A held level pin, which must send again only after an end-of-interrupt with the matching vector.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

  typedef struct packed {
    logic [7:0] dest;
    logic       mask;
    logic       trig;   // 1 = level
    logic       pol;    // 1 = active low
    logic       dlog;   // 1 = logical destination
    logic [2:0] dmode;
    logic [7:0] vec;
  } route_cfg_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_OFFER = 2'd1,
    ST_WAIT  = 2'd2
  } deliv_state_e;

endpackage

// File: rtl/irq_pin_detect.sv
module irq_pin_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  input  logic active_low_i,
  output logic level_o,
  output logic rise_o
);

  logic s1_q, s2_q, s3_q, filt_q;
  logic act2, act3, filt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      s3_q   <= 1'b0;
      filt_q <= 1'b0;
    end else begin
      s1_q   <= pin_i;
      s2_q   <= s1_q;
      s3_q   <= s2_q;
      filt_q <= filt;
    end
  end

  // active for two consecutive synchronized samples
  assign act2    = s2_q ^ active_low_i;
  assign act3    = s3_q ^ active_low_i;
  assign filt    = act2 & act3;
  assign level_o = filt;
  assign rise_o  = filt & ~filt_q;

endmodule

// File: rtl/irq_rr_arbiter.sv
module irq_rr_arbiter #(
  parameter int N    = 24,
  parameter int IDXW = $clog2(N)
) (
  input  logic [N-1:0]    req_i,
  input  logic [IDXW-1:0] ptr_i,
  output logic [IDXW-1:0] gnt_o,
  output logic            any_o
);

  always_comb begin
    gnt_o = '0;
    any_o = 1'b0;
    for (int k = 0; k < N; k++) begin
      int idx;
      idx = int'(ptr_i) + k;
      if (idx >= N) idx = idx - N;
      if (!any_o && req_i[idx]) begin
        any_o = 1'b1;
        gnt_o = IDXW'(idx);
      end
    end
  end

endmodule

// File: rtl/irq_route_table.sv
module irq_route_table
  import irq_route_pkg::*;
#(
  parameter int NUM_IN   = 24,
  parameter int BASE_IDX = 16,
  parameter int IDXW     = $clog2(NUM_IN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        reg_idx,
  input  logic [31:0]       reg_wdata,
  input  logic              reg_we,
  output logic [31:0]       reg_rdata,
  input  logic [NUM_IN-1:0] ds_i,
  input  logic [NUM_IN-1:0] rirr_i,
  output route_cfg_t        cfg_o [NUM_IN]
);

  localparam int SPAN = 2 * NUM_IN;

  logic [8:0]      off;
  logic            in_range;
  logic [IDXW-1:0] ent;
  route_cfg_t      cfg_q [NUM_IN];

  assign off      = {1'b0, reg_idx} - 9'(BASE_IDX);
  assign in_range = (int'(reg_idx) >= BASE_IDX) && (int'(off) < SPAN);
  assign ent      = IDXW'(off >> 1);

  for (genvar g = 0; g < NUM_IN; g++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cfg_q[g] <= route_cfg_t'(0);
        cfg_q[g].mask <= 1'b1;
      end else if (reg_we && in_range && (int'(ent) == g)) begin
        if (!off[0]) begin
          cfg_q[g].vec   <= reg_wdata[7:0];
          cfg_q[g].dmode <= reg_wdata[10:8];
          cfg_q[g].dlog  <= reg_wdata[11];
          cfg_q[g].pol   <= reg_wdata[13];
          cfg_q[g].trig  <= reg_wdata[15];
          cfg_q[g].mask  <= reg_wdata[16];
        end else begin
          cfg_q[g].dest  <= reg_wdata[31:24];
        end
      end
    end
    assign cfg_o[g] = cfg_q[g];
  end

  always_comb begin
    reg_rdata = '0;
    if (in_range) begin
      if (off[0]) begin
        reg_rdata = {cfg_q[ent].dest, 24'h0};
      end else begin
        reg_rdata = {15'h0, cfg_q[ent].mask, cfg_q[ent].trig, rirr_i[ent],
                     cfg_q[ent].pol, ds_i[ent], cfg_q[ent].dlog,
                     cfg_q[ent].dmode, cfg_q[ent].vec};
      end
    end
  end

endmodule

// File: rtl/irq_route_top.sv
module irq_route_top
  import irq_route_pkg::*;
#(
  parameter int NUM_IN   = 24,
  parameter int BASE_IDX = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_IN-1:0] irq_in,
  input  logic [7:0]        reg_idx,
  input  logic [31:0]       reg_wdata,
  input  logic              reg_we,
  output logic [31:0]       reg_rdata,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [7:0]        req_vector,
  output logic [2:0]        req_dmode,
  output logic              req_logical,
  output logic [7:0]        req_dest,
  input  logic              resp_valid,
  input  logic              resp_accept,
  input  logic              eoi_valid,
  input  logic [7:0]        eoi_vector
);

  localparam int IDXW = $clog2(NUM_IN);

  route_cfg_t        cfg [NUM_IN];
  logic [NUM_IN-1:0] lvl, rise, mask_v, trig_v, set_v, clr_v, eoi_hit, rset_v;
  logic [NUM_IN-1:0] ds_q, rirr_q;
  logic [IDXW-1:0]   gnt, sel_q, ptr_q;
  logic              any;
  logic              accept_hit;
  deliv_state_e      st_q;

  irq_route_table #(.NUM_IN(NUM_IN), .BASE_IDX(BASE_IDX), .IDXW(IDXW)) u_table (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_idx   (reg_idx),
    .reg_wdata (reg_wdata),
    .reg_we    (reg_we),
    .reg_rdata (reg_rdata),
    .ds_i      (ds_q),
    .rirr_i    (rirr_q),
    .cfg_o     (cfg)
  );

  assign accept_hit = (st_q == ST_WAIT) && resp_valid && resp_accept;

  for (genvar g = 0; g < NUM_IN; g++) begin : g_pin
    irq_pin_detect u_det (
      .clk          (clk),
      .rst_n        (rst_n),
      .pin_i        (irq_in[g]),
      .active_low_i (cfg[g].pol),
      .level_o      (lvl[g]),
      .rise_o       (rise[g])
    );
    assign mask_v[g]  = cfg[g].mask;
    assign trig_v[g]  = cfg[g].trig;
    assign set_v[g]   = ~mask_v[g] & ~ds_q[g] &
                        (trig_v[g] ? (lvl[g] & ~rirr_q[g]) : rise[g]);
    assign clr_v[g]   = accept_hit && (int'(sel_q) == g);
    assign rset_v[g]  = clr_v[g] & trig_v[g];
    assign eoi_hit[g] = eoi_valid & trig_v[g] & (cfg[g].vec == eoi_vector);

    // masked entries never take a new delivery status
    p_mask_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ds_q[g]) |-> !$past(mask_v[g]));
    // a level entry with remote pending set cannot re-arm
    p_level_block_r12: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(ds_q[g]) && $past(trig_v[g])) |-> !$past(rirr_q[g]));
  end

  irq_rr_arbiter #(.N(NUM_IN), .IDXW(IDXW)) u_arb (
    .req_i (ds_q & ~mask_v),
    .ptr_i (ptr_q),
    .gnt_o (gnt),
    .any_o (any)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ds_q   <= '0;
      rirr_q <= '0;
    end else begin
      ds_q   <= (ds_q | set_v) & ~clr_v;
      rirr_q <= (rirr_q & ~eoi_hit) | rset_v;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= ST_IDLE;
      sel_q       <= '0;
      ptr_q       <= '0;
      req_vector  <= '0;
      req_dmode   <= '0;
      req_logical <= 1'b0;
      req_dest    <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (any) begin
          st_q        <= ST_OFFER;
          sel_q       <= gnt;
          ptr_q       <= (int'(gnt) == NUM_IN - 1) ? '0 : gnt + 1'b1;
          req_vector  <= cfg[gnt].vec;
          req_dmode   <= cfg[gnt].dmode;
          req_logical <= cfg[gnt].dlog;
          req_dest    <= cfg[gnt].dlog ? cfg[gnt].dest : {4'h0, cfg[gnt].dest[3:0]};
        end
        ST_OFFER: if (req_ready) st_q <= ST_WAIT;
        ST_WAIT:  if (resp_valid) st_q <= ST_IDLE;
        default:  st_q <= ST_IDLE;
      endcase
    end
  end

  assign req_valid = (st_q == ST_OFFER);

  p_offer_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_vector) && $stable(req_dest)));

  p_offer_pending_r6: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> ds_q[sel_q]);

endmodule

// File: tb/tb_irq_route_top.sv
module tb_irq_route_top;

  localparam int CLK_PERIOD = 10;
  localparam int NI = 24;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NI-1:0] irq_in = '0;
  logic [7:0]    reg_idx = '0;
  logic [31:0]   reg_wdata = '0;
  logic          reg_we = 1'b0;
  logic [31:0]   reg_rdata;
  logic          req_valid;
  logic          req_ready = 1'b0;
  logic [7:0]    req_vector;
  logic [2:0]    req_dmode;
  logic          req_logical;
  logic [7:0]    req_dest;
  logic          resp_valid = 1'b0;
  logic          resp_accept = 1'b0;
  logic          eoi_valid = 1'b0;
  logic [7:0]    eoi_vector = '0;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  irq_route_top #(.NUM_IN(NI), .BASE_IDX(16)) dut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
    .reg_idx(reg_idx), .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_rdata(reg_rdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_vector(req_vector),
    .req_dmode(req_dmode), .req_logical(req_logical), .req_dest(req_dest),
    .resp_valid(resp_valid), .resp_accept(resp_accept),
    .eoi_valid(eoi_valid), .eoi_vector(eoi_vector)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_low(input logic [7:0] vec, input logic [2:0] dm,
      input logic dl, input logic pol, input logic trig, input logic msk);
    return {15'h0, msk, trig, 1'b0, pol, 1'b0, dl, dm, vec};
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; irq_in = '0; req_ready = 1'b0; resp_valid = 1'b0; eoi_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] idx, input logic [31:0] d);
    @(negedge clk);
    reg_idx = idx; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] idx, output logic [31:0] d);
    @(negedge clk);
    reg_idx = idx;
    #1;
    d = reg_rdata;
  endtask

  task automatic pulse(input int pin, input logic act_lvl, input int cycles);
    @(negedge clk);
    irq_in[pin] = act_lvl;
    repeat (cycles) @(negedge clk);
    irq_in[pin] = ~act_lvl;
  endtask

  task automatic wait_req(output bit found);
    found = 1'b0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (req_valid) begin
        found = 1'b1;
        break;
      end
    end
  endtask

  task automatic respond(input logic acc);
    req_ready = 1'b1;
    @(negedge clk);
    req_ready = 1'b0;
    resp_valid = 1'b1; resp_accept = acc;
    @(negedge clk);
    resp_valid = 1'b0; resp_accept = 1'b0;
  endtask

  task automatic no_req(input int cycles, input string tag);
    bit seen;
    seen = 1'b0;
    for (int k = 0; k < cycles; k++) begin
      @(negedge clk);
      if (req_valid) seen = 1'b1;
    end
    chk(!seen, tag, {31'h0, seen}, 32'h0);
  endtask

  task automatic expect_req(input logic [7:0] vec, input string tag);
    bit f;
    wait_req(f);
    chk(f, {tag, " request seen"}, {31'h0, f}, 32'h1);
    chk(req_vector == vec, {tag, " vector"}, {24'h0, req_vector}, {24'h0, vec});
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    n_cmp++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    finish_run();
  end

  initial begin
    logic [31:0] d, e;
    bit f;
    do_reset();

    // R1: reset state
    chk(req_valid == 1'b0, "R1 req_valid after reset", {31'h0, req_valid}, 32'h0);
    for (int i = 0; i < NI; i++) begin
      rd(8'(16 + 2*i), d);
      chk((d & 32'h0001_5000) == 32'h0001_0000, "R1 low word mask set", d & 32'h0001_5000, 32'h0001_0000);
    end

    // R2 R3: register sweep with all-ones and arithmetic patterns
    for (int i = 0; i < NI; i++) begin
      wr(8'(16 + 2*i), 32'hFFFF_FFFF);
      rd(8'(16 + 2*i), d);
      chk(d == 32'h0001_AFFF, "R3 low all-ones readback", d, 32'h0001_AFFF);
      wr(8'(17 + 2*i), 32'hFFFF_FFFF);
      rd(8'(17 + 2*i), d);
      chk(d == 32'hFF00_0000, "R2 high all-ones readback", d, 32'hFF00_0000);
      e = 32'h0001_0000 | ((i * 32'h0000_0B3D) & 32'h0000_AFFF);
      wr(8'(16 + 2*i), e | 32'hFFFE_5000);
      rd(8'(16 + 2*i), d);
      chk(d == e, "R2 low pattern readback", d, e);
      wr(8'(17 + 2*i), {8'(i * 11 + 3), 24'hABCDEF});
      rd(8'(17 + 2*i), d);
      chk(d == {8'(i * 11 + 3), 24'h0}, "R2 high pattern readback", d, {8'(i * 11 + 3), 24'h0});
    end

    // R4: out-of-range indices
    for (int x = 0; x < 256; x++) begin
      if (x >= 16 && x < 64) continue;
      wr(8'(x), 32'h5A5A_5A5A);
      rd(8'(x), d);
      chk(d == 32'h0, "R4 out-of-range read", d, 32'h0);
    end
    for (int i = 0; i < NI; i++) begin
      rd(8'(17 + 2*i), d);
      chk(d == {8'(i * 11 + 3), 24'h0}, "R4 entry untouched", d, {8'(i * 11 + 3), 24'h0});
    end

    // R6 R9 R10: delivery sweep over every pin
    for (int i = 0; i < NI; i++) begin
      logic [7:0] vec, dst, edst;
      logic dl;
      vec = 8'(8'h30 + i);
      dst = 8'(8'h90 + i);
      dl  = 1'(i % 2);
      edst = dl ? dst : {4'h0, dst[3:0]};
      wr(8'(17 + 2*i), {dst, 24'h0});
      wr(8'(16 + 2*i), mk_low(vec, 3'(i % 8), dl, 1'b0, 1'b0, 1'b0));
      repeat (4) @(negedge clk);
      pulse(i, 1'b1, 2);
      expect_req(vec, "R9 sweep");
      chk(req_dmode == 3'(i % 8), "R9 dmode", {29'h0, req_dmode}, 32'(i % 8));
      chk(req_logical == dl, "R9 dest mode", {31'h0, req_logical}, {31'h0, dl});
      chk(req_dest == edst, "R9 dest", {24'h0, req_dest}, {24'h0, edst});
      if (i == 0) begin
        repeat (3) @(negedge clk);
        chk(req_valid && req_vector == vec, "R10 held under back-pressure", {23'h0, req_valid, req_vector}, {23'h0, 1'b1, vec});
      end
      rd(8'(16 + 2*i), d);
      chk(d[12] == 1'b1, "R6 status set while pending", {31'h0, d[12]}, 32'h1);
      req_ready = 1'b1;
      @(negedge clk);
      req_ready = 1'b0;
      if (i == 0) begin
        repeat (3) @(negedge clk);
        chk(!req_valid, "R10 no request before response", {31'h0, req_valid}, 32'h0);
      end
      resp_valid = 1'b1; resp_accept = 1'b1;
      @(negedge clk);
      resp_valid = 1'b0; resp_accept = 1'b0;
      rd(8'(16 + 2*i), d);
      chk(d[12] == 1'b0, "R6 status clear after accept", {31'h0, d[12]}, 32'h0);
    end

    // R11: round robin with retry
    do_reset();
    wr(8'(16 + 6), mk_low(8'h53, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0));
    wr(8'(16 + 14), mk_low(8'h57, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0));
    @(negedge clk);
    irq_in[3] = 1'b1; irq_in[7] = 1'b1;
    repeat (2) @(negedge clk);
    irq_in[3] = 1'b0; irq_in[7] = 1'b0;
    expect_req(8'h53, "R11 first grant");
    respond(1'b0);
    rd(8'(16 + 6), d);
    chk(d[12] == 1'b1, "R11 status kept on retry", {31'h0, d[12]}, 32'h1);
    expect_req(8'h57, "R11 rotation after retry");
    respond(1'b1);
    expect_req(8'h53, "R11 retried entry re-queued");
    respond(1'b1);
    no_req(20, "R11 no extra request");

    // R5: glitch filter and polarity
    wr(8'(16 + 8), mk_low(8'h44, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0));
    pulse(4, 1'b1, 1);
    no_req(20, "R5 one-clock pulse ignored");
    pulse(4, 1'b1, 2);
    expect_req(8'h44, "R5 two-clock pulse");
    respond(1'b1);
    @(negedge clk);
    irq_in[8] = 1'b1;
    repeat (4) @(negedge clk);
    wr(8'(16 + 16), mk_low(8'h48, 3'd0, 1'b0, 1'b1, 1'b0, 1'b0));
    no_req(10, "R5 inactive-high pin quiet");
    pulse(8, 1'b0, 2);
    expect_req(8'h48, "R5 active-low edge");
    respond(1'b1);

    // R7: edge lock
    wr(8'(16 + 10), mk_low(8'h65, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0));
    pulse(5, 1'b1, 2);
    expect_req(8'h65, "R7 first edge");
    pulse(5, 1'b1, 3);
    repeat (4) @(negedge clk);
    respond(1'b1);
    no_req(25, "R7 second edge ignored");

    // R8: mask
    wr(8'(16 + 12), mk_low(8'h66, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1));
    pulse(6, 1'b1, 3);
    no_req(20, "R8 masked pin silent");
    rd(8'(16 + 12), d);
    chk(d[12] == 1'b0, "R8 masked status clear", {31'h0, d[12]}, 32'h0);

    // R12: level mode with remote pending
    wr(8'(16 + 20), mk_low(8'h7A, 3'd0, 1'b0, 1'b1, 1'b1, 1'b1));
    @(negedge clk);
    irq_in[10] = 1'b1;
    repeat (4) @(negedge clk);
    wr(8'(16 + 20), mk_low(8'h7A, 3'd0, 1'b0, 1'b1, 1'b1, 1'b0));
    no_req(8, "R12 inactive level quiet");
    @(negedge clk);
    irq_in[10] = 1'b0;
    expect_req(8'h7A, "R12 level request");
    respond(1'b1);
    rd(8'(16 + 20), d);
    chk(d[14] == 1'b1, "R12 remote pending set", {31'h0, d[14]}, 32'h1);
    no_req(20, "R12 blocked while remote pending");
    @(negedge clk);
    eoi_valid = 1'b1; eoi_vector = 8'h11;
    @(negedge clk);
    eoi_valid = 1'b0;
    no_req(20, "R12 non-matching eoi");
    @(negedge clk);
    eoi_valid = 1'b1; eoi_vector = 8'h7A;
    @(negedge clk);
    eoi_valid = 1'b0;
    expect_req(8'h7A, "R12 re-sent after matching eoi");
    irq_in[10] = 1'b1;
    respond(1'b1);
    @(negedge clk);
    eoi_valid = 1'b1; eoi_vector = 8'h7A;
    @(negedge clk);
    eoi_valid = 1'b0;
    no_req(20, "R12 released level quiet");
    rd(8'(16 + 20), d);
    chk(d[14] == 1'b0, "R12 remote pending cleared", {31'h0, d[14]}, 32'h0);

    finish_run();
  end

endmodule